// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block produces the shared time base for a two-channel PWM unit. A 16-bit counter advances once per prescaled tick and can count up, count down, count up and then down, or hold. Downstream compare and action logic uses the counter value and two single-clock event strobes. One strobe marks an update that lands on zero. The other marks an update that lands on the active period.

Software uses one write port with two targets. `wr_sel` = 0 writes the control word and `wr_sel` = 1 writes the period. The control word chooses the count direction, the tick rate and how period writes take effect. It also sets the run behaviour: halt after one more tick, halt when the cycle returns to zero, or run without stopping. In shadow mode a period write is held back until the counter reaches zero, so a cycle that is in progress never sees a partial period.

Top module: `pwm_timebase`

## Requirements
- R1: A synchronous active-high reset clears the counter, both strobes, both period registers and every control field. After reset the block is stopped in up mode with both divider factors equal to 1, and the counter stays at 0 until a control write starts it.
- R2: In up mode (control bits [1:0] = 00), each tick adds one to the counter. A tick taken while the counter is at or above the active period returns the counter to 0.
- R3: In down mode (bits [1:0] = 01), each tick subtracts one from the counter. A tick taken at 0 reloads the active period.
- R4: In up-down mode (bits [1:0] = 10), the counter climbs to the period and then falls to 0. At the top it turns and steps down; at 0 it turns and steps up, or stays at 0 when the period is 0. The direction starts upward after reset and is kept across stops and mode changes.
- R5: In hold mode (bits [1:0] = 11), the counter keeps its value and neither strobe fires.
- R6: Control bits [12:10] hold a field k and bits [9:7] hold a field m. The counter advances once every 2^k × f clock cycles, where f = 1 when m = 0 and f = 2m otherwise. This count starts again from every control write, so the first advance comes exactly that many cycles after the write edge.
- R7: With control bit 3 = 0, a period write goes only to the shadow register. The shadow is copied into the active period on each count update that yields 0. If a period write falls in the same cycle as that copy, the copy takes the previous shadow value, and the new value waits for the next zero.
- R8: With control bit 3 = 1, a period write replaces the active period at once. The next tick already uses the new value.
- R9: Run field bits [15:14] = 00: a running counter advances on its next tick and then halts, keeping its value.
- R10: Run field 01: a running counter halts right after the update that brings it to 0.
- R11: Run fields 11 and 10 both run freely. A control write with a run field other than 00 starts a stopped counter.
- R12: `zero_o` and `prd_o` each stay high for one clock, in the cycle where `cnt_o` first shows the new value of 0 or the active period. With a period of 0, both fire together. Neither fires while the counter is stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_sel | input | 1 | Write target: 0 control word, 1 period |
| wr_data | input | CNT_W | Write data (the control word uses bits [15:0]) |
| cnt_o | output | CNT_W | Time-base counter value |
| zero_o | output | 1 | Update landed on zero |
| prd_o | output | 1 | Update landed on the active period |

## Verification
A period write can fall in the same cycle as the shadow-to-active copy at zero. The bench waits until the counter sits at the active period with a one-cycle tick, then issues the period write in the same cycle as the wrapping update. The cycles that follow are judged against a model in which the wrap uses the old shadow value and the new value waits for the next zero. A second collision pairs the zero and period strobes: with a period of 0, both strobes must fire together on every tick.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;

  localparam int CTRL_W = 16;

  typedef enum logic [1:0] {
    CM_UP   = 2'b00,
    CM_DOWN = 2'b01,
    CM_UPDN = 2'b10,
    CM_HOLD = 2'b11
  } cnt_mode_e;

  typedef enum logic [1:0] {
    RUN_STEP  = 2'b00,
    RUN_CYCLE = 2'b01,
    RUN_ALT   = 2'b10,
    RUN_FREE  = 2'b11
  } run_mode_e;

  typedef struct packed {
    run_mode_e run;
    logic [2:0] div1;
    logic [2:0] div2;
    logic       prd_imm;
    cnt_mode_e  mode;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{run: RUN_STEP, div1: 3'd0, div2: 3'd0,
                                 prd_imm: 1'b0, mode: CM_UP};

  function automatic ctrl_t decode_ctrl(input logic [CTRL_W-1:0] d);
    ctrl_t c;
    c.run     = run_mode_e'(d[15:14]);
    c.div1    = d[12:10];
    c.div2    = d[9:7];
    c.prd_imm = d[3];
    c.mode    = cnt_mode_e'(d[1:0]);
    return c;
  endfunction

endpackage

// File: rtl/pwm_tb_prescaler.sv
module pwm_tb_prescaler #(
  parameter int DIV1_W = 3,
  parameter int DIV2_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic [DIV1_W-1:0] div1,
  input  logic [DIV2_W-1:0] div2,
  output logic              tick
);
  localparam int S1_W = (1 << DIV1_W) - 1;
  localparam int S2_W = DIV2_W + 1;

  logic [S1_W-1:0] s1_q, lim1;
  logic [S2_W-1:0] s2_q, lim2;
  logic            s1_wrap, s2_wrap;

  // first stage limit: 2^div1 - 1 as a thermometer of ones
  always_comb begin
    for (int i = 0; i < S1_W; i++) begin
      lim1[i] = (i < int'(div1));
    end
  end

  // second stage limit: 0 for field 0, else 2*field - 1
  assign lim2 = (div2 == '0) ? '0 : S2_W'({div2, 1'b0} - 1'b1);

  assign s1_wrap = (s1_q == lim1);
  assign s2_wrap = (s2_q == lim2);
  assign tick    = en && s1_wrap && s2_wrap;

  always_ff @(posedge clk) begin
    if (rst || clr || !en) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= s1_wrap ? '0 : s1_q + 1'b1;
      if (s1_wrap) begin
        s2_q <= s2_wrap ? '0 : s2_q + 1'b1;
      end
    end
  end

  AST_PS_BOUND: assert property (@(posedge clk) disable iff (rst)
    (s1_q <= lim1) && (s2_q <= lim2)); // R6

endmodule

// File: rtl/pwm_tb_period.sv
module pwm_tb_period #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_prd,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             imm,
  input  logic             load_zero,
  output logic [CNT_W-1:0] act_prd
);
  logic [CNT_W-1:0] shd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shd_q   <= '0;
      act_prd <= '0;
    end else begin
      if (wr_prd) begin
        shd_q <= wr_data;
      end
      if (wr_prd && imm) begin
        act_prd <= wr_data;
      end else if (!imm && load_zero) begin
        act_prd <= shd_q;
      end
    end
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!imm && !load_zero && !wr_prd) |=> $stable(act_prd)); // R7

  AST_IMM_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_prd && imm) |=> (act_prd == $past(wr_data))); // R8

endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  cnt_mode_e        mode_i,
  input  run_mode_e        run_i,
  input  logic             start_req,
  input  logic [CNT_W-1:0] act_prd,
  output logic [CNT_W-1:0] cnt_q,
  output logic             evt_zero_q,
  output logic             evt_prd_q,
  output logic             running,
  output logic             load_zero
);
  typedef enum logic {ST_STOP, ST_RUN} run_st_e;

  run_st_e          state_q;
  logic             down_q, down_n;
  logic [CNT_W-1:0] nxt;
  logic             adv, prd_hit, stop_now;

  assign adv = tick && (mode_i != CM_HOLD);

  always_comb begin
    nxt    = cnt_q;
    down_n = down_q;
    unique case (mode_i)
      CM_UP:   nxt = (cnt_q >= act_prd) ? '0 : cnt_q + 1'b1;
      CM_DOWN: nxt = (cnt_q == '0) ? act_prd : cnt_q - 1'b1;
      CM_UPDN: begin
        if (!down_q) begin
          if (cnt_q >= act_prd) begin
            down_n = 1'b1;
            nxt    = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
          end else begin
            nxt = cnt_q + 1'b1;
          end
        end else begin
          if (cnt_q == '0) begin
            down_n = 1'b0;
            nxt    = (act_prd == '0) ? '0 : CNT_W'(1);
          end else begin
            nxt = cnt_q - 1'b1;
          end
        end
      end
      default: nxt = cnt_q;
    endcase
  end

  assign load_zero = adv && (nxt == '0);
  assign prd_hit   = adv && (nxt == act_prd);
  assign running   = (state_q == ST_RUN);
  assign stop_now  = ((run_i == RUN_STEP) && tick) ||
                     ((run_i == RUN_CYCLE) && load_zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      down_q     <= 1'b0;
      evt_zero_q <= 1'b0;
      evt_prd_q  <= 1'b0;
    end else begin
      evt_zero_q <= load_zero;
      evt_prd_q  <= prd_hit;
      if (adv) begin
        cnt_q  <= nxt;
        down_q <= down_n;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_STOP;
    end else if (start_req) begin
      state_q <= ST_RUN;
    end else if (running && stop_now) begin
      state_q <= ST_STOP;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q)); // R6

  AST_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (mode_i == CM_UP && tick && cnt_q >= act_prd) |=> (cnt_q == '0)); // R2

  AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (mode_i == CM_HOLD) |=> ($stable(cnt_q) && !evt_zero_q && !evt_prd_q)); // R5

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STOP) |=> (!evt_zero_q && !evt_prd_q)); // R12

  AST_CYCLE_END: assert property (@(posedge clk) disable iff (rst)
    (running && run_i == RUN_CYCLE && load_zero && !start_req) |=> !running); // R10

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o,
  output logic             prd_o
);
  ctrl_t            ctrl_q, ctrl_d;
  logic             ctrl_wr, prd_wr, start_req;
  logic             tick, running, load_zero;
  logic [CNT_W-1:0] act_prd;

  assign ctrl_wr   = wr_en && !wr_sel;
  assign prd_wr    = wr_en && wr_sel;
  assign ctrl_d    = decode_ctrl(wr_data[CTRL_W-1:0]);
  assign start_req = ctrl_wr && (ctrl_d.run != RUN_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
    end else if (ctrl_wr) begin
      ctrl_q <= ctrl_d;
    end
  end

  pwm_tb_prescaler #(.DIV1_W(3), .DIV2_W(3)) u_ps (
    .clk  (clk),
    .rst  (rst),
    .clr  (ctrl_wr),
    .en   (running),
    .div1 (ctrl_q.div1),
    .div2 (ctrl_q.div2),
    .tick (tick)
  );

  pwm_tb_period #(.CNT_W(CNT_W)) u_prd (
    .clk       (clk),
    .rst       (rst),
    .wr_prd    (prd_wr),
    .wr_data   (wr_data),
    .imm       (ctrl_q.prd_imm),
    .load_zero (load_zero),
    .act_prd   (act_prd)
  );

  pwm_tb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .mode_i     (ctrl_q.mode),
    .run_i      (ctrl_q.run),
    .start_req  (start_req),
    .act_prd    (act_prd),
    .cnt_q      (cnt_o),
    .evt_zero_q (zero_o),
    .evt_prd_q  (prd_o),
    .running    (running),
    .load_zero  (load_zero)
  );

endmodule

// File: tb/tb_pwm_timebase.sv
`timescale 1ns/1ps
module tb_pwm_timebase;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic             wr_sel = 1'b0;
  logic [CNT_W-1:0] wr_data = '0;
  logic [CNT_W-1:0] cnt_o;
  logic             zero_o, prd_o;

  int vectors = 0;
  int errors  = 0;
  bit armed   = 1'b0;
  string tag  = "R1";

  always #2.5 clk = ~clk;

  pwm_timebase #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cnt_o(cnt_o), .zero_o(zero_o), .prd_o(prd_o)
  );

  // reference state, built from the requirements
  int m_cnt = 0, m_act = 0, m_shd = 0, m_pc = 0, m_div = 1;
  int m_mode = 0, m_runm = 0;
  bit m_dn = 0, m_run = 0, m_imm = 0, m_ez = 0, m_ep = 0;

  function automatic void mdl_next(input int mode, input int cnt, input int prd,
                                   input bit dn, output int nx, output bit dno);
    dno = dn;
    nx  = cnt;
    case (mode)
      0: nx = (cnt >= prd) ? 0 : cnt + 1;
      1: nx = (cnt == 0) ? prd : cnt - 1;
      2: begin
        if (!dn) begin
          if (cnt < prd) nx = cnt + 1;
          else begin dno = 1; nx = (cnt > 0) ? cnt - 1 : 0; end
        end else begin
          if (cnt > 0) nx = cnt - 1;
          else begin dno = 0; nx = (prd > 0) ? 1 : 0; end
        end
      end
      default: nx = cnt;
    endcase
  endfunction

  function automatic int div_of(input logic [15:0] d);
    int f2;
    f2 = (d[9:7] == 3'd0) ? 1 : 2 * int'(d[9:7]);
    return (1 << int'(d[12:10])) * f2;
  endfunction

  always @(posedge clk) begin
    int nx;
    bit nd, tk, ad, zr, pk, wc, wp;
    if (rst) begin
      m_cnt <= 0; m_act <= 0; m_shd <= 0; m_pc <= 0; m_div <= 1;
      m_mode <= 0; m_runm <= 0; m_dn <= 0; m_run <= 0; m_imm <= 0;
      m_ez <= 0; m_ep <= 0;
    end else begin
      wc = wr_en && !wr_sel;
      wp = wr_en && wr_sel;
      tk = m_run && (m_pc == m_div - 1);
      ad = tk && (m_mode != 3);
      mdl_next(m_mode, m_cnt, m_act, m_dn, nx, nd);
      zr = ad && (nx == 0);
      pk = ad && (nx == m_act);
      m_ez <= zr;
      m_ep <= pk;
      if (ad) begin m_cnt <= nx; m_dn <= nd; end
      if (wp) m_shd <= int'(wr_data);
      if (wp && m_imm) m_act <= int'(wr_data);
      else if (!m_imm && zr) m_act <= m_shd;
      if (wc) begin
        m_mode <= int'(wr_data[1:0]);
        m_imm  <= wr_data[3];
        m_runm <= int'(wr_data[15:14]);
        m_div  <= div_of(wr_data[15:0]);
      end
      if (wc && wr_data[15:14] != 2'b00) m_run <= 1;
      else if (m_run && ((m_runm == 0 && tk) || (m_runm == 1 && zr))) m_run <= 0;
      m_pc <= (wc || !m_run) ? 0 : (tk ? 0 : m_pc + 1);
    end
  end

  function automatic string mode_tag();
    case (m_mode)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic compare();
    string t;
    if (!armed) return;
    t = (tag == "") ? mode_tag() : tag;
    vectors++;
    if (int'(cnt_o) != m_cnt || zero_o != m_ez || prd_o != m_ep) begin
      errors++;
      $display("FAIL %s cnt=%0d exp %0d zero=%0b exp %0b prd=%0b exp %0b",
               t, cnt_o, m_cnt, zero_o, m_ez, prd_o, m_ep);
    end
  endtask

  task automatic check_val(input string t, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      wr_en = 1'b0;
    end
  endtask

  task automatic wr(input bit sel, input logic [15:0] d);
    @(negedge clk);
    compare();
    wr_en   = 1'b1;
    wr_sel  = sel;
    wr_data = d;
    step(1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int c0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    armed = 1'b1;
    // R1: reset state and no motion without a start
    check_val("R1", int'(cnt_o), 0);
    check_val("R1", int'(zero_o) + int'(prd_o), 0);
    tag = "R1"; step(20);
    check_val("R1", int'(cnt_o), 0);

    // R12: period 0 -> both strobes together each tick
    tag = "R12"; wr(0, 16'hC008); step(10);
    check_val("R12", int'(zero_o) + int'(prd_o), 2);
    // R8: immediate period load
    tag = "R8"; wr(1, 16'd5); step(20);
    tag = "R2"; step(30);
    // R6: prescaler 4 * 6 = 24, then 128 * 14
    tag = "R6"; wr(0, 16'hC008 | (16'd2 << 10) | (16'd3 << 7)); step(300);
    wr(0, 16'hC008 | (16'd7 << 10) | (16'd7 << 7)); step(4000);
    wr(0, 16'hC008 | (16'd0 << 10) | (16'd1 << 7)); step(40);
    // R3, R4, R5
    tag = "R3"; wr(0, 16'hC009); step(40);
    tag = "R4"; wr(0, 16'hC00A); step(40);
    wr(1, 16'd0); step(10); wr(1, 16'd4); step(30);
    tag = "R5"; wr(0, 16'hC00B); step(20);
    // R7: shadow load and write colliding with the zero copy
    tag = "R7"; wr(0, 16'hC000); wr(1, 16'd9); step(30);
    wr(1, 16'd6); step(3);
    while (int'(cnt_o) != m_act) step(1);
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 16'd3;
    step(60);
    // R9: halt after one more tick
    tag = "R9"; wr(0, 16'h0000); step(10);
    c0 = int'(cnt_o); step(10);
    check_val("R9", int'(cnt_o), c0);
    // R10: run to end of cycle and halt at zero
    tag = "R10"; wr(0, 16'h4000); step(40);
    check_val("R10", int'(cnt_o), 0);
    step(10);
    check_val("R10", int'(cnt_o), 0);
    // R11: run field 10 runs freely
    tag = "R11"; wr(0, 16'h8000); step(50);
    wr(0, 16'hC000); step(20);

    // constrained random mix
    tag = "";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 6) begin
        logic [15:0] d;
        d = '0;
        d[15:14] = 2'($urandom_range(0, 3));
        d[12:10] = 3'($urandom_range(0, 2));
        d[9:7]   = 3'($urandom_range(0, 3));
        d[3]     = 1'($urandom_range(0, 1));
        d[1:0]   = 2'($urandom_range(0, 3));
        wr(0, d);
      end else if (r < 14) begin
        wr(1, 16'($urandom_range(0, 20)));
      end else begin
        step(1);
      end
    end
    step(5);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule